// File: doc/BRIEF.md
# Dual Supply Reset and Watchdog Supervisor

This block is the digital core of a processor supervisor. It takes two comparator outputs, one that goes high while the main supply is under its threshold and one that goes high while a secondary supply is under its threshold. It also takes a watchdog service input with an enable, and a clock of known frequency. From these it drives an active-high system reset and a secondary power-fail flag.

Reset is held after power-up and whenever the main supply is low. It is stretched by a fixed settle time once the supply has recovered. A watchdog that the processor fails to service for a set period also pulses reset for the same settle time and then starts counting again. The secondary flag follows its comparator through a synchroniser and has no stretch.

The comparator and service inputs are treated as asynchronous and pass through `SYNC_STAGES` flip-flops. All delays below are counted in rising clock edges after an input changes. Edge 1 is the first rising edge after the change.

Top module: `sv_supervisor`

## Requirements
- R1: While `rst_ni` is low, `reset_o` is 1 and `sec_fail_o` is 0.
- R2: After `rst_ni` rises, with `vmain_low_i` low and the watchdog disabled, `reset_o` stays 1 through edge `HOLD_CYCLES-1` and is 0 after edge `HOLD_CYCLES`.
- R3: When `vmain_low_i` rises, `reset_o` is still unchanged after edge `SYNC_STAGES` and is 1 after edge `SYNC_STAGES+1`. It stays 1 for as long as the input stays high.
- R4: When `vmain_low_i` falls, `reset_o` is still 1 after edge `SYNC_STAGES+HOLD_CYCLES-1` and is 0 after edge `SYNC_STAGES+HOLD_CYCLES`. A new dip during the hold time restarts the full hold from its own recovery.
- R5: With the watchdog enabled and never serviced, `reset_o` rises `WDT_CYCLES` edges after it last fell. It then stays 1 for exactly `HOLD_CYCLES` edges, and the cycle repeats.
- R6: Only a 0-to-1 transition of `wdt_kick_i` services the watchdog. After such a transition with no further one, the timeout reset rises at edge `SYNC_STAGES+1+WDT_CYCLES`. A kick input that is held high gives no further service.
- R7: The watchdog count is held at zero while `reset_o` is 1. Kicks during reset have no effect, and counting starts at the edge where reset falls.
- R8: While `wdt_en_i` is 0, no watchdog timeout occurs. When it rises with reset low, a timeout follows after `WDT_CYCLES` edges unless the watchdog is serviced.
- R9: `sec_fail_o` equals `vsec_low_i` delayed by `SYNC_STAGES` edges, regardless of reset or watchdog state.
- R10: A main-supply low takes precedence over a coincident watchdog timeout. The hold time is always measured from the later of supply recovery and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| vmain_low_i | input | 1 | Main supply below threshold (async) |
| vsec_low_i | input | 1 | Secondary supply below threshold (async) |
| wdt_en_i | input | 1 | Watchdog enable |
| wdt_kick_i | input | 1 | Watchdog service, rising edge (async) |
| reset_o | output | 1 | System reset, active high |
| sec_fail_o | output | 1 | Secondary supply fail flag |

## Verification
The hardest case to reach is a supply dip that lands inside a hold window that is already running. The same applies to a watchdog timeout that lands on the same edge as a supply event. From the ports both need precise relative timing. The directed part places a dip a few cycles into a hold, and kicks during a reset window. A seeded random phase then toggles the supply, kick and enable inputs at rates chosen so that timeouts, dips and recoveries overlap, and each edge is compared with a bench model of the stated latencies.

// File: rtl/sv_sup_pkg.sv
package sv_sup_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/sv_sup_sync.sv
module sv_sup_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[0] <= RST_VAL;
        else         sr_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= RST_VAL;
        else         sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sv_sup_edge.sv
module sv_sup_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/sv_sup_hold.sv
module sv_sup_hold
  import sv_sup_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic fire_i,
  output logic reset_o
);
  localparam int unsigned CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  hold_state_e    state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (trip_i || fire_i) begin
      // any cause restarts the full settle time
      state_d = ST_HOLD;
      cnt_d   = '0;
    end else if (state_q == ST_HOLD) begin
      if (cnt_q == LAST) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign reset_o = (state_q == ST_HOLD);
endmodule

// File: rtl/sv_sup_wdt.sv
module sv_sup_wdt #(
  parameter int unsigned WDT_CYCLES = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic halt_i,
  input  logic kick_i,
  output logic fire_o
);
  localparam int unsigned CW = (WDT_CYCLES > 2) ? $clog2(WDT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run;

  assign run    = en_i & ~halt_i;
  assign fire_o = run & ~kick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run || kick_i || fire_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sv_supervisor.sv
module sv_supervisor #(
  parameter int unsigned HOLD_CYCLES = 15000,
  parameter int unsigned WDT_CYCLES  = 15000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vmain_low_i,
  input  logic vsec_low_i,
  input  logic wdt_en_i,
  input  logic wdt_kick_i,
  output logic reset_o,
  output logic sec_fail_o
);
  logic main_low_s;
  logic kick_s;
  logic kick_rise;
  logic wd_fire;
  logic rst_hold;

  sv_sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vmain_low_i), .q_o(main_low_s)
  );

  sv_sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vsec_low_i), .q_o(sec_fail_o)
  );

  sv_sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_kick (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wdt_kick_i), .q_o(kick_s)
  );

  sv_sup_edge u_kick_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(kick_s), .rise_o(kick_rise)
  );

  sv_sup_wdt #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(wdt_en_i), .halt_i(rst_hold),
    .kick_i(kick_rise), .fire_o(wd_fire)
  );

  sv_sup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .trip_i(main_low_s), .fire_i(wd_fire),
    .reset_o(rst_hold)
  );

  assign reset_o = rst_hold;
endmodule

// File: rtl/sv_supervisor_chk.sv
module sv_supervisor_chk #(
  parameter int unsigned HOLD_CYCLES = 15000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic vsec_low_i,
  input logic wdt_en_i,
  input logic reset_o,
  input logic sec_fail_o,
  input logic main_low_s,
  input logic wd_fire
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hi_run <= '0;
    else if (!reset_o)       hi_run <= '0;
    else if (hi_run != HMAX) hi_run <= hi_run + 1'b1;
  end

  AST_RST_ACTIVE: assert property (@(posedge clk_i)
    !rst_ni |-> (reset_o && !sec_fail_o)); // R1

  AST_UV_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_low_s |=> reset_o); // R3

  AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_o) |-> (hi_run >= HW'(HOLD_CYCLES))); // R4

  AST_FIRE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |=> reset_o); // R5

  AST_QUIET_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> !wd_fire); // R7

  AST_QUIET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_i |-> !wd_fire); // R8

  AST_SEC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_fail_o) |-> $past(vsec_low_i, SYNC_STAGES)); // R9

  AST_SEC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sec_fail_o) |-> !$past(vsec_low_i, SYNC_STAGES)); // R9
endmodule

bind sv_supervisor sv_supervisor_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .vsec_low_i(vsec_low_i),
  .wdt_en_i(wdt_en_i),
  .reset_o(reset_o),
  .sec_fail_o(sec_fail_o),
  .main_low_s(main_low_s),
  .wd_fire(wd_fire)
);

// File: tb/tb_sv_supervisor.sv
module tb_sv_supervisor;
  localparam int HOLD = 40;
  localparam int WDT  = 60;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic vmain = 1'b0, vsec = 1'b0, wen = 1'b0, kick = 1'b0;
  logic reset_w, sec_w;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sv_supervisor #(.HOLD_CYCLES(HOLD), .WDT_CYCLES(WDT), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .vmain_low_i(vmain), .vsec_low_i(vsec),
    .wdt_en_i(wen), .wdt_kick_i(kick), .reset_o(reset_w), .sec_fail_o(sec_w)
  );

  // reference built from the stated latencies
  logic [SYNC-1:0] m_mq, m_sq, m_kq;
  logic m_kprev, m_rst;
  int   m_hc, m_wc;

  function automatic bit wd_timeout(bit en, bit in_rst, int wc, bit kp);
    return en && !in_rst && (wc == WDT - 1) && !kp;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mq <= '0; m_sq <= '0; m_kq <= '0; m_kprev <= 1'b0;
      m_rst <= 1'b1; m_hc <= 0; m_wc <= 0;
    end else begin
      bit kp, fire, mlow;
      kp   = m_kq[SYNC-1] & ~m_kprev;
      fire = wd_timeout(wen, m_rst, m_wc, kp);
      mlow = m_mq[SYNC-1];
      if (!wen || m_rst || kp || fire) m_wc <= 0;
      else                             m_wc <= m_wc + 1;
      if (mlow || fire) begin
        m_rst <= 1'b1; m_hc <= 0;
      end else if (m_rst) begin
        if (m_hc == HOLD - 1) begin m_rst <= 1'b0; m_hc <= 0; end
        else m_hc <= m_hc + 1;
      end
      m_kprev <= m_kq[SYNC-1];
      m_mq <= {m_mq[SYNC-2:0], vmain};
      m_sq <= {m_sq[SYNC-2:0], vsec};
      m_kq <= {m_kq[SYNC-2:0], kick};
    end
  end

  task automatic check(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    step(3);
    check(reset_w, 1'b1, "R1 reset during rst");
    check(sec_w, 1'b0, "R1 sec during rst");
    rst_n = 1'b1;
    step(HOLD - 1); check(reset_w, 1'b1, "R2 POR hold");
    step(1);        check(reset_w, 1'b0, "R2 POR release");

    vmain = 1'b1;
    step(SYNC); check(reset_w, 1'b0, "R3 before latency");
    step(1);    check(reset_w, 1'b1, "R3 asserted");
    step(20);   check(reset_w, 1'b1, "R3 held");
    vmain = 1'b0;
    step(SYNC + HOLD - 1); check(reset_w, 1'b1, "R4 hold");
    step(1);               check(reset_w, 1'b0, "R4 release");

    vmain = 1'b1; step(10); vmain = 1'b0; step(10);
    vmain = 1'b1; step(3);  vmain = 1'b0;
    step(SYNC + HOLD - 1); check(reset_w, 1'b1, "R4 dip restarts hold");
    step(1);               check(reset_w, 1'b0, "R4 release after dip");

    vsec = 1'b1;
    step(SYNC - 1); check(sec_w, 1'b0, "R9 before latency");
    step(1);        check(sec_w, 1'b1, "R9 set");
    vsec = 1'b0;
    step(SYNC);     check(sec_w, 1'b0, "R9 clear");

    wen = 1'b1;
    step(WDT - 1); check(reset_w, 1'b0, "R8 enable no early fire");
    step(1);       check(reset_w, 1'b1, "R8 timeout after enable");
    step(HOLD - 1); check(reset_w, 1'b1, "R5 timeout hold");
    step(1);        check(reset_w, 1'b0, "R5 timeout release");
    step(WDT - 1);  check(reset_w, 1'b0, "R5 period");
    step(1);        check(reset_w, 1'b1, "R5 repeat");
    step(HOLD);     check(reset_w, 1'b0, "R5 second release");

    step(10); kick = 1'b1;
    step(SYNC + WDT); check(reset_w, 1'b0, "R6 kick restarts");
    step(1);          check(reset_w, 1'b1, "R6 timeout after kick");
    step(HOLD);       check(reset_w, 1'b0, "R6 release");
    step(WDT - 1);    check(reset_w, 1'b0, "R6 level held");
    step(1);          check(reset_w, 1'b1, "R6 level gives no service");
    kick = 1'b0;

    step(5); kick = 1'b1; step(3); kick = 1'b0;
    step(HOLD - 8); check(reset_w, 1'b0, "R7 release");
    step(WDT - 1);  check(reset_w, 1'b0, "R7 count from release");
    step(1);        check(reset_w, 1'b1, "R7 kick in reset ignored");

    wen = 1'b0;
    step(HOLD);    check(reset_w, 1'b0, "R8 release");
    step(3 * WDT); check(reset_w, 1'b0, "R8 disabled no timeout");

    // R10 timeout and dip on the same edges: main low arrives as timeout fires
    wen = 1'b1;
    step(WDT - SYNC - 1); vmain = 1'b1; step(SYNC + 1);
    check(reset_w, 1'b1, "R10 coincident trip");
    step(5); vmain = 1'b0;
    step(SYNC + HOLD - 1); check(reset_w, 1'b1, "R10 hold from recovery");
    step(1);               check(reset_w, 1'b0, "R10 release");

    void'($urandom(32'd7));
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      check(reset_w, m_rst, "R3/R4/R5/R6 random reset");
      check(sec_w, m_sq[SYNC-1], "R9 random sec");
      if ($urandom_range(0, 199) == 0) vmain = ~vmain;
      if (vmain && $urandom_range(0, 15) == 0) vmain = 1'b0;
      if ($urandom_range(0, 9) == 0) vsec = ~vsec;
      if ($urandom_range(0, 24) == 0) kick = ~kick;
      if ($urandom_range(0, 999) == 0) wen = ~wen;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule